// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits between a synchronous host and a 1M x 16 pseudo-static RAM that is kept in its default SRAM-style asynchronous mode. The host issues one access at a time with a request/ready handshake: a 20-bit word address, a read/write flag, 16 bits of write data and two active-high byte enables. The controller turns each request into a cycle-counted sequence of chip enable, output enable, write enable, byte-lane enables and address valid on the memory pins. It drives the shared 16-bit data bus only while it is writing, and returns read data to the host with a one-cycle valid pulse.

After reset the controller waits out the memory's self-initialization time, about 150 microseconds. During that time chip enable stays high and no request is accepted. The read access time, the write pulse width and the recovery gap are parameters counted in system clock cycles. The power-up count comes from the clock frequency in MHz times the hold-off time in microseconds. The memory clock pin is tied low. Chip enable is released after every access, so no single low period grows without bound.

Top module: `psram_async_ctrl`

## Requirements
- R1: From reset release until PWRUP_CYC clock cycles have passed, mem_ce_n stays 1 and host_rdy stays 0; host_rdy rises within a few cycles after that.
- R2: A read holds mem_ce_n and mem_oe_n low and mem_we_n high. mem_oe_n stays low for exactly ACCESS_CYC cycles. The data bus is sampled in the last of those cycles, and host_rvalid is seen ACCESS_CYC+1 cycles after the accepting edge.
- R3: A write holds mem_ce_n low for one setup cycle and then holds mem_we_n low for exactly WRITE_CYC cycles. mem_oe_n stays 1 whenever mem_we_n is 0.
- R4: At the end of a write, mem_ce_n, mem_we_n and both lane enables rise on the same edge. The write data stays driven, unchanged, on mem_dq for the following cycle.
- R5: mem_adv_n is 0 whenever mem_ce_n is 0. mem_addr holds the accepted address, unchanged, for as long as mem_ce_n is low.
- R6: mem_clk is 0 at all times.
- R7: After every access mem_ce_n returns high for at least RECOV_CYC cycles. A single low period of mem_ce_n lasts at most the larger of ACCESS_CYC and WRITE_CYC+1 cycles.
- R8: Host byte enable bit 0 maps to mem_lb_n and data bits 7:0; bit 1 maps to mem_ub_n and data bits 15:8. A lane enable pin is low during an access only when its bit is set. On a read, the lanes that are not selected return zero in host_rdata.
- R9: The controller drives mem_dq only during a write, and never while mem_oe_n is low. Its driver is already off in the cycle before mem_oe_n falls.
- R10: host_rdy is 1 only when the controller is idle, and it is 0 in the cycle after a request is accepted. host_rvalid is a single-cycle pulse.
- R11: A request with both byte enables 0 causes no falling edge on mem_ce_n. A read of this kind returns host_rvalid one cycle after acceptance, with host_rdata equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request, taken when host_rdy is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Active-high byte enables (bit 0 low byte) |
| host_rdy | output | 1 | Controller idle and able to accept |
| host_rvalid | output | 1 | One-cycle read data valid |
| host_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_adv_n | output | 1 | Address valid, held low through each access |
| mem_clk | output | 1 | Memory clock, constantly low |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The hardest case to reach from the ports is a write followed at once by a read. In that case the bus driver must already be off before the memory model starts driving, and the write data must survive the strobe release. Directed write-then-read pairs to the same address force this case, and random traffic drawn from a small address pool repeats it many times with mixed byte lanes. Skip requests with both enables clear are mixed into the stream, so that the bench can show chip enable never falls for them.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_RD       = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5,
        ST_RECOV    = 3'd6,
        ST_SKIP     = 3'd7
    } seq_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_pwrup_timer.sv
module psram_pwrup_timer #(
    parameter int CYCLES = 15000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.done) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            if (tmr_q.cnt == CNT_W'(CYCLES - 1)) begin
                tmr_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = tmr_q.done;

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int ACCESS_CYC = 7,
    parameter int WRITE_CYC  = 5,
    parameter int RECOV_CYC  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_done,
    input  logic                     req,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W/8-1:0]      req_be,
    output logic                     rdy,
    output logic                     rvalid,
    output logic [DATA_W-1:0]        rdata,
    input  logic [DATA_W-1:0]        dq_in,
    output logic [DATA_W-1:0]        dq_out,
    output logic                     dq_oe,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     ce_n,
    output logic                     oe_n,
    output logic                     we_n,
    output logic                     adv_n,
    output logic [DATA_W/8-1:0]      lane_n
);
    localparam int BE_W  = DATA_W / 8;
    localparam int MAXC  = max_of(max_of(ACCESS_CYC, WRITE_CYC), RECOV_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdat;
        logic [BE_W-1:0]     be;
        logic                ce_n;
        logic                oe_n;
        logic                we_n;
        logic                adv_n;
        logic [BE_W-1:0]     lane_n;
        logic                dq_oe;
        logic                rvalid;
        logic [DATA_W-1:0]   rdata;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic [DATA_W-1:0] sel_mask;

    // Expand the byte enables into a bit mask, one byte per lane.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane_mask
        assign sel_mask[g*8 +: 8] = {8{seq_q.be[g]}};
    end

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;

        case (seq_q.st)
            ST_PWRUP: begin
                if (pwr_done) begin
                    seq_d.st = ST_IDLE;
                end
            end

            ST_IDLE: begin
                if (req) begin
                    seq_d.addr = req_addr;
                    seq_d.wdat = req_wdata;
                    seq_d.be   = req_be;
                    seq_d.cnt  = '0;
                    if (req_be == '0) begin
                        // Nothing to move: finish without touching the bus.
                        seq_d.st     = ST_SKIP;
                        seq_d.rvalid = !req_we;
                        seq_d.rdata  = '0;
                    end else if (req_we) begin
                        seq_d.st     = ST_WR_SETUP;
                        seq_d.ce_n   = 1'b0;
                        seq_d.adv_n  = 1'b0;
                        seq_d.lane_n = ~req_be;
                        seq_d.dq_oe  = 1'b1;
                    end else begin
                        seq_d.st     = ST_RD;
                        seq_d.ce_n   = 1'b0;
                        seq_d.oe_n   = 1'b0;
                        seq_d.adv_n  = 1'b0;
                        seq_d.lane_n = ~req_be;
                    end
                end
            end

            ST_RD: begin
                if (seq_q.cnt == CNT_W'(ACCESS_CYC - 1)) begin
                    seq_d.rdata  = dq_in & sel_mask;
                    seq_d.rvalid = 1'b1;
                    seq_d.ce_n   = 1'b1;
                    seq_d.oe_n   = 1'b1;
                    seq_d.adv_n  = 1'b1;
                    seq_d.lane_n = '1;
                    seq_d.cnt    = '0;
                    seq_d.st     = ST_RECOV;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_WR_SETUP: begin
                seq_d.we_n = 1'b0;
                seq_d.cnt  = '0;
                seq_d.st   = ST_WR_PULSE;
            end

            ST_WR_PULSE: begin
                if (seq_q.cnt == CNT_W'(WRITE_CYC - 1)) begin
                    // All strobes rise together; data stays driven one more cycle.
                    seq_d.ce_n   = 1'b1;
                    seq_d.we_n   = 1'b1;
                    seq_d.adv_n  = 1'b1;
                    seq_d.lane_n = '1;
                    seq_d.st     = ST_WR_HOLD;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_WR_HOLD: begin
                seq_d.dq_oe = 1'b0;
                seq_d.cnt   = '0;
                seq_d.st    = ST_RECOV;
            end

            ST_RECOV: begin
                if (seq_q.cnt == CNT_W'(RECOV_CYC - 1)) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end

            ST_SKIP: begin
                seq_d.st = ST_IDLE;
            end

            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.st     <= ST_PWRUP;
            seq_q.ce_n   <= 1'b1;
            seq_q.oe_n   <= 1'b1;
            seq_q.we_n   <= 1'b1;
            seq_q.adv_n  <= 1'b1;
            seq_q.lane_n <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rdy      = (seq_q.st == ST_IDLE);
    assign rvalid   = seq_q.rvalid;
    assign rdata    = seq_q.rdata;
    assign dq_out   = seq_q.wdat;
    assign dq_oe    = seq_q.dq_oe;
    assign mem_addr = seq_q.addr;
    assign ce_n     = seq_q.ce_n;
    assign oe_n     = seq_q.oe_n;
    assign we_n     = seq_q.we_n;
    assign adv_n    = seq_q.adv_n;
    assign lane_n   = seq_q.lane_n;

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl #(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int CLK_MHZ    = 100,
    parameter int PWRUP_US   = 150,
    parameter int ACCESS_CYC = 7,
    parameter int WRITE_CYC  = 5,
    parameter int RECOV_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_be,
    output logic              host_rdy,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic              mem_adv_n,
    output logic              mem_clk,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;

    logic              pwr_done;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_out;
    logic [1:0]        lane_n;

    psram_pwrup_timer #(
        .CYCLES (PWRUP_CYC)
    ) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    psram_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ACCESS_CYC (ACCESS_CYC),
        .WRITE_CYC  (WRITE_CYC),
        .RECOV_CYC  (RECOV_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_done  (pwr_done),
        .req       (host_req),
        .req_we    (host_we),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .req_be    (host_be),
        .rdy       (host_rdy),
        .rvalid    (host_rvalid),
        .rdata     (host_rdata),
        .dq_in     (mem_dq),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .mem_addr  (mem_addr),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .adv_n     (mem_adv_n),
        .lane_n    (lane_n)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];
    assign mem_clk  = 1'b0;
    assign mem_dq   = dq_oe ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int DATA_W     = 16,
    parameter int ACCESS_CYC = 7,
    parameter int WRITE_CYC  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_done,
    input logic              host_rdy,
    input logic              host_rvalid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_adv_n,
    input logic              mem_clk,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out
);
    localparam int CE_MAX = (ACCESS_CYC > WRITE_CYC + 1) ? ACCESS_CYC : WRITE_CYC + 1;

    logic [7:0] ce_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_run_q <= '0;
        end else if (mem_ce_n) begin
            ce_run_q <= '0;
        end else if (ce_run_q != 8'hFF) begin
            ce_run_q <= ce_run_q + 1'b1;
        end
    end

    AST_PWRUP_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_done |-> (mem_ce_n && !host_rdy)); // R1

    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R2

    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R3

    AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_ce_n && mem_lb_n && mem_ub_n)); // R4

    AST_DATA_HELD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (dq_oe && $stable(dq_out))); // R4

    AST_ADV_DURING_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !mem_adv_n); // R5

    AST_CLK_TIED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_clk); // R6

    AST_CE_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ce_run_q <= 8'(CE_MAX)); // R7

    AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !dq_oe); // R9

    AST_DRIVER_OFF_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(dq_oe)); // R9

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid); // R10

endmodule

bind psram_async_ctrl psram_ctrl_chk #(
    .DATA_W     (DATA_W),
    .ACCESS_CYC (ACCESS_CYC),
    .WRITE_CYC  (WRITE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_done    (pwr_done),
    .host_rdy    (host_rdy),
    .host_rvalid (host_rvalid),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_lb_n    (mem_lb_n),
    .mem_ub_n    (mem_ub_n),
    .mem_adv_n   (mem_adv_n),
    .mem_clk     (mem_clk),
    .dq_oe       (dq_oe),
    .dq_out      (dq_out)
);

// File: tb/tb_psram_async_ctrl.sv
module tb_psram_async_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ACCESS_CYC = 7;
    localparam int WRITE_CYC  = 5;
    localparam int RECOV_CYC  = 2;
    localparam int CLK_MHZ    = 100;
    localparam int PWRUP_US   = 150;
    localparam int PWRUP_CYC  = CLK_MHZ * PWRUP_US;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [19:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_rdy, host_rvalid;
    logic [15:0] host_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_adv_n, mem_clk;
    wire  [15:0] mem_dq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_async_ctrl #(
        .CLK_MHZ (CLK_MHZ), .PWRUP_US (PWRUP_US),
        .ACCESS_CYC (ACCESS_CYC), .WRITE_CYC (WRITE_CYC), .RECOV_CYC (RECOV_CYC)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .host_req (host_req), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_be (host_be),
        .host_rdy (host_rdy), .host_rvalid (host_rvalid), .host_rdata (host_rdata),
        .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n), .mem_lb_n (mem_lb_n), .mem_ub_n (mem_ub_n),
        .mem_adv_n (mem_adv_n), .mem_clk (mem_clk), .mem_dq (mem_dq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'hA5C} ^ 16'h3C3C;
    endfunction

    function automatic logic [15:0] be_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // ---------------- memory model (pin level) ----------------
    logic [15:0] mdl [logic [19:0]];
    logic [15:0] mdl_out;

    function automatic logic [15:0] mdl_read(input logic [19:0] a);
        return mdl.exists(a) ? mdl[a] : init_word(a);
    endfunction

    always @(*) mdl_out = mdl_read(mem_addr);
    assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mdl_out : 16'hzzzz;

    // ---------------- bench shadow (intent level) ----------------
    logic [15:0] shd [logic [19:0]];

    function automatic logic [15:0] shd_read(input logic [19:0] a);
        return shd.exists(a) ? shd[a] : init_word(a);
    endfunction

    // ---------------- pin monitors at negedge ----------------
    int          oe_run = 0, we_run = 0, ce_gap = 1000;
    int          ce_falls = 0;
    bit          ce_prev = 1'b1, wr_prev = 1'b0;
    logic [19:0] acc_addr = '0, wr_addr = '0;
    logic [1:0]  wr_lanes = '0;
    logic [15:0] wr_seen = '0;
    logic [15:0] exp_wdata = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(mem_clk === 1'b0, "R6 mem_clk low", 32'(mem_clk), 0);
            if (!mem_ce_n) begin
                chk(mem_adv_n === 1'b0, "R5 adv low while ce low", 32'(mem_adv_n), 0);
                if (ce_prev) begin
                    ce_falls++;
                    acc_addr = mem_addr;
                    chk(ce_gap >= RECOV_CYC, "R7 ce high gap", ce_gap, RECOV_CYC);
                end else begin
                    chk(mem_addr === acc_addr, "R5 address stable", 32'(mem_addr), 32'(acc_addr));
                end
                ce_gap = 0;
            end else begin
                ce_gap++;
            end
            ce_prev = mem_ce_n;

            if (!mem_we_n) chk(mem_oe_n === 1'b1, "R3 oe high during write", 32'(mem_oe_n), 1);

            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                chk(oe_run == ACCESS_CYC, "R2 oe low width", oe_run, ACCESS_CYC);
                oe_run = 0;
            end

            if (!mem_we_n) begin
                we_run++;
                wr_seen  = mem_dq;
                wr_addr  = mem_addr;
                wr_lanes = {~mem_ub_n, ~mem_lb_n};
            end else if (we_run > 0) begin
                chk(we_run == WRITE_CYC, "R3 we low width", we_run, WRITE_CYC);
                we_run = 0;
            end

            // Commit on the first cycle after the write strobes release.
            if (wr_prev && mem_we_n) begin
                chk(mem_ce_n && mem_lb_n && mem_ub_n, "R4 strobes released together",
                    {mem_ce_n, mem_lb_n, mem_ub_n}, 3'b111);
                chk(mem_dq === wr_seen && mem_dq === exp_wdata, "R4 data held after strobe",
                    32'(mem_dq), 32'(exp_wdata));
                mdl[wr_addr] = (mdl_read(wr_addr) & ~be_mask(wr_lanes)) | (mem_dq & be_mask(wr_lanes));
            end
            wr_prev = !mem_we_n;
        end
    end

    // ---------------- host access task ----------------
    task automatic host_op(input bit w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        int          lat;
        int          falls0;
        logic [15:0] exp;
        while (!host_rdy) @(negedge clk);
        falls0     = ce_falls;
        exp_wdata  = d;
        host_req   = 1'b1;
        host_we    = w;
        host_addr  = a;
        host_wdata = d;
        host_be    = be;
        exp        = shd_read(a) & be_mask(be);
        if (w) shd[a] = (shd_read(a) & ~be_mask(be)) | (d & be_mask(be));
        @(negedge clk);
        host_req = 1'b0;
        chk(host_rdy === 1'b0, "R10 rdy low after accept", 32'(host_rdy), 0);
        if (!w) begin
            lat = 1;
            while (!host_rvalid && lat < 50) begin
                @(negedge clk);
                lat++;
            end
            if (be == 2'b00) begin
                chk(lat == 1, "R11 skip read latency", lat, 1);
                chk(host_rdata === 16'h0, "R11 skip read data zero", 32'(host_rdata), 0);
            end else begin
                chk(lat == ACCESS_CYC + 1, "R2 read latency", lat, ACCESS_CYC + 1);
                chk(host_rdata === exp, "R8 read data lanes", 32'(host_rdata), 32'(exp));
            end
            @(negedge clk);
            chk(host_rvalid === 1'b0, "R10 rvalid single pulse", 32'(host_rvalid), 0);
        end
        while (!host_rdy) @(negedge clk);
        if (be == 2'b00) chk(ce_falls == falls0, "R11 no ce activity", ce_falls, falls0);
        else             chk(ce_falls == falls0 + 1, "R7 one ce pulse per access", ce_falls, falls0 + 1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int          bad_lock;
        int          wait_cyc;
        logic [19:0] pool [16];
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED1234);

        repeat (4) @(negedge clk);
        chk(mem_ce_n === 1'b1 && host_rdy === 1'b0, "R1 reset state",
            {mem_ce_n, host_rdy}, 2'b10);
        rst_n = 1'b1;

        // R1: lockout throughout the power-up window
        bad_lock = 0;
        for (int i = 0; i < PWRUP_CYC; i++) begin
            @(negedge clk);
            if (mem_ce_n !== 1'b1 || host_rdy !== 1'b0) bad_lock++;
        end
        chk(bad_lock == 0, "R1 lockout held", bad_lock, 0);
        wait_cyc = 0;
        while (!host_rdy && wait_cyc < 8) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk(host_rdy === 1'b1, "R1 ready after power-up", 32'(host_rdy), 1);

        // Directed corner cases
        host_op(1'b0, 20'h00000, 16'h0000, 2'b11);         // R2 untouched word
        host_op(1'b1, 20'h00000, 16'hBEEF, 2'b11);         // R3 full write
        host_op(1'b0, 20'h00000, 16'h0000, 2'b11);         // R9 write then read turnaround
        host_op(1'b1, 20'hFFFFF, 16'h1234, 2'b01);         // R8 low lane only
        host_op(1'b0, 20'hFFFFF, 16'h0000, 2'b11);
        host_op(1'b1, 20'hFFFFF, 16'hAB00, 2'b10);         // R8 high lane only
        host_op(1'b0, 20'hFFFFF, 16'h0000, 2'b10);
        host_op(1'b0, 20'hFFFFF, 16'h0000, 2'b01);
        host_op(1'b1, 20'h00000, 16'hDEAD, 2'b00);         // R11 skipped write
        host_op(1'b0, 20'h00000, 16'h0000, 2'b11);         // R11 shows memory untouched
        host_op(1'b0, 20'h00000, 16'h0000, 2'b00);         // R11 skipped read
        host_op(1'b0, 20'h00000, 16'h0000, 2'b00);         // R10 back-to-back skips

        // Constrained random traffic over a small address pool
        for (int i = 0; i < 16; i++) pool[i] = 20'($urandom());
        for (int n = 0; n < 400; n++) begin
            logic [1:0] be;
            be = ($urandom_range(0, 9) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
            host_op(1'($urandom()), pool[$urandom_range(0, 15)], 16'($urandom()), be);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule